// File: doc/BRIEF.md
# Windowed external interrupt controller

This block gathers a parameterised number of level-sensitive external interrupt lines (up to 512, in multiples of 16) for a machine-mode core. It decides whether any of them should interrupt the hart, and which one should be served first. Each line has an enable bit, a software force bit and a 4-bit priority. A line counts as pending when its request input is high or its force bit is set. It becomes eligible when it is also enabled and its priority is at least the current preemption level.

Software reaches the block through a single-cycle CSR-style port. The port has a register selector, an operation code (read, write, set, clear) and 32-bit write data. The wide enable, force and pending vectors are never exposed whole. Each access works on one 16-bit window, chosen by the low bits of the write data, and the window contents travel in the upper half. Priorities use the same scheme with four 4-bit fields per window. A read of the next-interrupt register returns the winning index already scaled for a table of 32-bit handler pointers. The same read retires that interrupt's force bit.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all enable, force and priority bits and the preemption level are zero. The pending output is low, and the next-interrupt register reads 0x8000_0000 while no line is high.
- R2: Interrupt n lives in window n/16 at bit n%16. For the pending (select 0), enable (select 1) and force (select 2) views, write data bits [4:0] pick the window. A read returns that window in [31:16], the window number in [4:0] and zero in [15:5].
- R3: The operation code is 0 = read, 1 = write (replace the window with data [31:16]), 2 = set (OR data [31:16] into the window) and 3 = clear (remove the data [31:16] bits from the window). Bits in other windows are untouched.
- R4: A window number at or above NUM_IRQ/16 reads zero data, with its number still echoed, and writes to it change no stored bit.
- R5: The pending view is request line OR force bit. A forced line counts as pending while its request input is low.
- R6: The priority view (select 3) uses write data bits [6:0] as window w, covering interrupts 4w to 4w+3. Interrupt 4w+j has its priority in bits [16+4j+3:16+4j]. Reads echo w in [6:0], and write, set and clear act as in R3.
- R7: The preemption level (select 4) is a 4-bit register in bits [3:0], modified by write, set and clear. An interrupt is eligible only if it is pending, enabled and its priority is greater than or equal to the level.
- R8: ext_irq_pending_o is registered. It is high in the cycle after any interrupt was eligible, and low in the cycle after none was.
- R9: The next-interrupt register (select 5) returns the winning index in bits [10:2] with all other bits zero. When nothing is eligible it returns only bit 31 set.
- R10: A higher priority wins. Among eligible interrupts of equal priority, the lowest index wins.
- R11: Any access to select 5 while an interrupt is eligible clears that winner's force bit at the end of the access cycle. A winner whose request line stays high remains pending.
- R12: Write, set and clear accesses to the pending view and to the next-interrupt register change no stored state except as stated in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | NUM_IRQ | Level-sensitive request lines, already synchronous to clk_i |
| csr_en_i | input | 1 | Access valid for this cycle |
| csr_sel_i | input | 3 | Register select: 0 pending, 1 enable, 2 force, 3 priority, 4 level, 5 next |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Window number in the low bits, window data in [31:16] |
| csr_rdata_o | output | 32 | Combinational read data for the selected register and window |
| ext_irq_pending_o | output | 1 | Registered external-interrupt-pending flag |

## Verification
The assertions take for granted that the request lines are already synchronous to the clock. They also assume that select, operation and write data are stable whenever the access strobe is high, and that NUM_IRQ is a multiple of 16. The stimulus keeps within this by changing every input on the falling edge, one access per cycle with the strobe dropped between accesses. It holds reset for several cycles before the first access. The clocked properties on window updates and force retirement therefore only ever see well-formed single-cycle accesses.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
    localparam int WIN_W   = 16;
    localparam int PRIO_W  = 4;
    localparam int IDX_W   = 9;
    localparam int DATA_W  = 32;
    localparam int IDX_LSB = 2;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        SEL_PEND  = 3'd0,
        SEL_EN    = 3'd1,
        SEL_FORCE = 3'd2,
        SEL_PRIO  = 3'd3,
        SEL_LEVEL = 3'd4,
        SEL_NEXT  = 3'd5
    } csr_sel_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    function automatic logic [WIN_W-1:0] apply_op(csr_op_e op,
                                                  logic [WIN_W-1:0] cur,
                                                  logic [WIN_W-1:0] d);
        case (op)
            OP_WRITE: return d;
            OP_SET:   return cur | d;
            OP_CLEAR: return cur & ~d;
            default:  return cur;
        endcase
    endfunction

    // Left operand always carries the lower indices, so ties keep it.
    function automatic cand_t pick_better(cand_t lo, cand_t hi);
        if (hi.valid && (!lo.valid || hi.prio > lo.prio))
            return hi;
        return lo;
    endfunction
endpackage

// File: rtl/xirq_winarray.sv
`timescale 1ns/1ps
module xirq_winarray
    import xirq_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int SEL_W   = 5
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     acc_i,
    input  csr_op_e                  op_i,
    input  logic [SEL_W-1:0]         win_i,
    input  logic [WIN_W-1:0]         data_i,
    input  logic                     kill_i,
    input  logic [SEL_W+3:0]         kill_idx_i,
    output logic [NUM_WIN*WIN_W-1:0] bits_o,
    output logic [WIN_W-1:0]         rd_win_o
);
    logic [WIN_W-1:0] mem [NUM_WIN];

    function automatic logic [WIN_W-1:0] win_of(logic [NUM_WIN*WIN_W-1:0] v,
                                                logic [SEL_W-1:0] w);
        logic [WIN_W-1:0] r;
        r = '0;
        for (int k = 0; k < NUM_WIN; k++)
            if (w == SEL_W'(k)) r = v[k*WIN_W +: WIN_W];
        return r;
    endfunction

    generate
        for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
            localparam logic [SEL_W-1:0] WSEL = SEL_W'(w);
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    mem[w] <= '0;
                end else begin
                    if (acc_i && win_i == WSEL)
                        mem[w] <= apply_op(op_i, mem[w], data_i);
                    if (kill_i && kill_idx_i[SEL_W+3:4] == WSEL)
                        mem[w][kill_idx_i[3:0]] <= 1'b0;
                end
            end
            assign bits_o[w*WIN_W +: WIN_W] = mem[w];
        end
    endgenerate

    assign rd_win_o = win_of(bits_o, win_i);

    p_set_bits_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && op_i == OP_SET && !kill_i && win_i < SEL_W'(NUM_WIN))
        |=> ((win_of(bits_o, $past(win_i)) & $past(data_i)) == $past(data_i)));

    p_clear_bits_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && op_i == OP_CLEAR && win_i < SEL_W'(NUM_WIN))
        |=> ((win_of(bits_o, $past(win_i)) & $past(data_i)) == '0));

    p_oob_stable_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && !kill_i && win_i >= SEL_W'(NUM_WIN)) |=> $stable(bits_o));
endmodule

// File: rtl/xirq_select.sv
`timescale 1ns/1ps
module xirq_select
    import xirq_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_IRQ-1:0]        pend_i,
    input  logic [NUM_IRQ-1:0]        en_i,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         level_i,
    output logic [NUM_IRQ-1:0]        elig_o,
    output cand_t                     best_o
);
    localparam int LVLS   = $clog2(NUM_IRQ);
    localparam int LEAVES = 1 << LVLS;
    localparam int NODES  = 2 * LEAVES - 1;

    cand_t tree [NODES];

    generate
        for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
            if (i < NUM_IRQ) begin : g_real
                assign elig_o[i] = pend_i[i] & en_i[i] &
                                   (prio_i[i*PRIO_W +: PRIO_W] >= level_i);
                assign tree[LEAVES-1+i] = '{valid: elig_o[i],
                                            prio:  prio_i[i*PRIO_W +: PRIO_W],
                                            idx:   IDX_W'(i)};
            end else begin : g_pad
                assign tree[LEAVES-1+i] = '0;
            end
        end
        for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
            assign tree[k] = pick_better(tree[2*k+1], tree[2*k+2]);
        end
    endgenerate

    assign best_o = tree[0];

    logic winner_elig;
    assign winner_elig = elig_o[best_o.idx[LVLS-1:0]];

    p_winner_eligible_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        best_o.valid |-> winner_elig);

    p_none_means_empty_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !best_o.valid |-> (elig_o == '0));

    p_winner_meets_level_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        best_o.valid |-> (best_o.prio >= level_i));
endmodule

// File: rtl/xirq_ctrl.sv
`timescale 1ns/1ps
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_IRQ-1:0] irq_lines_i,
    input  logic               csr_en_i,
    input  logic [2:0]         csr_sel_i,
    input  logic [1:0]         csr_op_i,
    input  logic [31:0]        csr_wdata_i,
    output logic [31:0]        csr_rdata_o,
    output logic               ext_irq_pending_o
);
    localparam int NWIN   = NUM_IRQ / WIN_W;
    localparam int NPWIN  = NUM_IRQ * PRIO_W / WIN_W;
    localparam int BSEL_W = 5;
    localparam int PSEL_W = 7;
    localparam int IW     = $clog2(NUM_IRQ);

    csr_sel_e sel;
    csr_op_e  op;
    logic     is_mod;
    assign sel    = csr_sel_e'(csr_sel_i);
    assign op     = csr_op_e'(csr_op_i);
    assign is_mod = csr_en_i && (op != OP_READ);

    logic [BSEL_W-1:0] bwin;
    logic [PSEL_W-1:0] pwin;
    logic [WIN_W-1:0]  wdat;
    assign bwin = csr_wdata_i[BSEL_W-1:0];
    assign pwin = csr_wdata_i[PSEL_W-1:0];
    assign wdat = csr_wdata_i[DATA_W-1:WIN_W];

    logic [NUM_IRQ-1:0]        en_bits, force_bits, pend, elig;
    logic [NUM_IRQ*PRIO_W-1:0] prio_bits;
    logic [WIN_W-1:0]          en_win, force_win, prio_win;
    logic [PRIO_W-1:0]         level_q;
    cand_t                     best;
    logic                      next_acc;

    assign next_acc = csr_en_i && sel == SEL_NEXT && best.valid;

    xirq_winarray #(.NUM_WIN(NWIN), .SEL_W(BSEL_W)) u_enable (
        .clk_i, .rst_i,
        .acc_i(is_mod && sel == SEL_EN), .op_i(op), .win_i(bwin), .data_i(wdat),
        .kill_i(1'b0), .kill_idx_i('0),
        .bits_o(en_bits), .rd_win_o(en_win)
    );

    xirq_winarray #(.NUM_WIN(NWIN), .SEL_W(BSEL_W)) u_force (
        .clk_i, .rst_i,
        .acc_i(is_mod && sel == SEL_FORCE), .op_i(op), .win_i(bwin), .data_i(wdat),
        .kill_i(next_acc), .kill_idx_i(best.idx),
        .bits_o(force_bits), .rd_win_o(force_win)
    );

    xirq_winarray #(.NUM_WIN(NPWIN), .SEL_W(PSEL_W)) u_prio (
        .clk_i, .rst_i,
        .acc_i(is_mod && sel == SEL_PRIO), .op_i(op), .win_i(pwin), .data_i(wdat),
        .kill_i(1'b0), .kill_idx_i('0),
        .bits_o(prio_bits), .rd_win_o(prio_win)
    );

    assign pend = irq_lines_i | force_bits;

    xirq_select #(.NUM_IRQ(NUM_IRQ)) u_select (
        .clk_i, .rst_i,
        .pend_i(pend), .en_i(en_bits), .prio_i(prio_bits), .level_i(level_q),
        .elig_o(elig), .best_o(best)
    );

    // Preemption level register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= '0;
        end else if (is_mod && sel == SEL_LEVEL) begin
            case (op)
                OP_WRITE: level_q <= csr_wdata_i[PRIO_W-1:0];
                OP_SET:   level_q <= level_q | csr_wdata_i[PRIO_W-1:0];
                OP_CLEAR: level_q <= level_q & ~csr_wdata_i[PRIO_W-1:0];
                default:  level_q <= level_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ext_irq_pending_o <= 1'b0;
        else       ext_irq_pending_o <= |elig;
    end

    logic [WIN_W-1:0]  pend_win;
    logic [DATA_W-1:0] next_val;

    always_comb begin
        pend_win = '0;
        for (int w = 0; w < NWIN; w++)
            if (bwin == BSEL_W'(w)) pend_win = pend[w*WIN_W +: WIN_W];
    end

    assign next_val = best.valid
        ? {{(DATA_W-IDX_W-IDX_LSB){1'b0}}, best.idx, {IDX_LSB{1'b0}}}
        : {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        case (sel)
            SEL_PEND:  csr_rdata_o = {pend_win,  {(WIN_W-BSEL_W){1'b0}}, bwin};
            SEL_EN:    csr_rdata_o = {en_win,    {(WIN_W-BSEL_W){1'b0}}, bwin};
            SEL_FORCE: csr_rdata_o = {force_win, {(WIN_W-BSEL_W){1'b0}}, bwin};
            SEL_PRIO:  csr_rdata_o = {prio_win,  {(WIN_W-PSEL_W){1'b0}}, pwin};
            SEL_LEVEL: csr_rdata_o = {{(DATA_W-PRIO_W){1'b0}}, level_q};
            SEL_NEXT:  csr_rdata_o = next_val;
            default:   csr_rdata_o = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{csr_wdata_i[WIN_W-1:PSEL_W], best.prio};

    p_force_retired_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        next_acc |=> !force_bits[$past(best.idx[IW-1:0])]);

    p_pend_rises_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (|elig) |=> ext_irq_pending_o);

    p_pend_falls_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|elig) |=> !ext_irq_pending_o);
endmodule

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb_top;
    localparam int N = 64;
    localparam logic [2:0] S_PEND = 3'd0, S_EN = 3'd1, S_FRC = 3'd2,
                           S_PRI = 3'd3, S_LVL = 3'd4, S_NXT = 3'd5;
    localparam logic [1:0] O_RD = 2'd0, O_WR = 2'd1, O_SET = 2'd2, O_CLR = 2'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_lines = '0;
    logic          csr_en = 1'b0;
    logic [2:0]    csr_sel = '0;
    logic [1:0]    csr_op = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          ext_pend;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    xirq_ctrl #(.NUM_IRQ(N)) dut_i (
        .clk_i(clk), .rst_i(rst), .irq_lines_i(irq_lines),
        .csr_en_i(csr_en), .csr_sel_i(csr_sel), .csr_op_i(csr_op),
        .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata),
        .ext_irq_pending_o(ext_pend)
    );

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int checks = 0;
    int errors = 0;

    task automatic note(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Driver: one access per cycle, expected read data goes to the scoreboard
    task automatic access(input logic [2:0] sel, input logic [1:0] op,
                          input logic [31:0] wd, input bit chk,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_sel   = sel;
        csr_op    = op;
        csr_wdata = wd;
        csr_en    = 1'b1;
        sb_q.push_back('{chk, exp, tag});
        @(posedge clk);
        #1 csr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, input logic [31:0] wd,
                      input logic [31:0] exp, input string tag);
        access(sel, O_RD, wd, 1'b1, exp, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [1:0] op, input logic [31:0] wd);
        access(sel, op, wd, 1'b0, '0, "");
    endtask

    task automatic pend_chk(input logic exp, input string tag);
        repeat (2) @(negedge clk);
        #1 note(ext_pend === exp, tag, {31'b0, ext_pend}, {31'b0, exp});
    endtask

    // Monitor: compares read data while the access is held
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (csr_en && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.chk) note(csr_rdata === it.exp, it.tag, csr_rdata, it.exp);
            end
        end
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(S_EN, 32'h0000_0000, 32'h0000_0000, "R1 enable window 0 after reset");
        rd(S_FRC, 32'h0000_0003, 32'h0000_0003, "R1 force window 3 after reset");
        rd(S_NXT, 32'h0, 32'h8000_0000, "R1 next empty after reset");
        rd(S_LVL, 32'h0, 32'h0, "R1 level after reset");
        pend_chk(1'b0, "R1 pending output low after reset");

        // R2 / R3 window access and operations
        wr(S_EN, O_WR, 32'hA5A5_0001);
        rd(S_EN, 32'h0000_0001, 32'hA5A5_0001, "R2 write into window 1");
        wr(S_EN, O_SET, 32'h0F00_0001);
        rd(S_EN, 32'h0000_0001, 32'hAFA5_0001, "R3 set ORs bits");
        wr(S_EN, O_CLR, 32'h00A5_0001);
        rd(S_EN, 32'h0000_0001, 32'hAF00_0001, "R3 clear removes bits");
        rd(S_EN, 32'h0000_0000, 32'h0000_0000, "R3 other window untouched");

        // R4 out-of-range windows
        wr(S_EN, O_WR, 32'hFFFF_0005);
        wr(S_EN, O_SET, 32'hFFFF_0004);
        rd(S_EN, 32'h0000_0005, 32'h0000_0005, "R4 out-of-range reads zero");
        rd(S_EN, 32'h0000_0001, 32'hAF00_0001, "R4 window 1 unchanged");
        rd(S_EN, 32'h0000_0000, 32'h0000_0000, "R4 window 0 unchanged");
        wr(S_EN, O_WR, 32'h0000_0001);

        // R5 pending view, R12 pending is read only
        @(negedge clk) irq_lines[20] = 1'b1;
        rd(S_PEND, 32'h0000_0001, 32'h0010_0001, "R5 line 20 pending");
        wr(S_FRC, O_SET, 32'h0008_0002);
        rd(S_FRC, 32'h0000_0002, 32'h0008_0002, "R5 force 35 stored");
        rd(S_PEND, 32'h0000_0002, 32'h0008_0002, "R5 forced 35 pending");
        wr(S_PEND, O_WR, 32'hFFFF_0001);
        rd(S_PEND, 32'h0000_0001, 32'h0010_0001, "R12 pending write ignored");
        rd(S_NXT, 32'h0, 32'h8000_0000, "R9 nothing enabled");

        // R8 / R9 single eligible interrupt
        wr(S_EN, O_SET, 32'h0010_0001);
        pend_chk(1'b1, "R8 pending output after enabling 20");
        rd(S_NXT, 32'h0, 32'h0000_0050, "R9 next index 20");
        rd(S_NXT, 32'h0, 32'h0000_0050, "R11 line-held 20 stays");

        // R10 / R6 / R11 priorities and force retirement
        wr(S_EN, O_SET, 32'h0008_0002);
        rd(S_NXT, 32'h0, 32'h0000_0050, "R10 tie picks lower index");
        wr(S_PRI, O_WR, 32'h5000_0008);
        rd(S_PRI, 32'h0000_0008, 32'h5000_0008, "R6 priority field of 35");
        rd(S_NXT, 32'h0, 32'h0000_008C, "R10 higher priority 35 wins");
        rd(S_FRC, 32'h0000_0002, 32'h0000_0002, "R11 force of 35 retired");
        rd(S_NXT, 32'h0, 32'h0000_0050, "R11 next falls back to 20");

        // R7 preemption level
        wr(S_LVL, O_WR, 32'h0000_0003);
        rd(S_LVL, 32'h0, 32'h0000_0003, "R7 level written");
        rd(S_NXT, 32'h0, 32'h8000_0000, "R7 below level not eligible");
        pend_chk(1'b0, "R8 pending output drops under level");
        wr(S_PRI, O_WR, 32'h0003_0005);
        rd(S_NXT, 32'h0, 32'h0000_0050, "R7 equal to level qualifies");
        pend_chk(1'b1, "R8 pending output back");

        // R10 equal priority across windows, then higher
        wr(S_FRC, O_SET, 32'h8000_0003);
        wr(S_EN, O_SET, 32'h8000_0003);
        wr(S_PRI, O_WR, 32'h3000_000F);
        rd(S_NXT, 32'h0, 32'h0000_0050, "R10 tie 20 vs 63");
        wr(S_PRI, O_WR, 32'h4000_000F);
        rd(S_NXT, 32'h0, 32'h0000_00FC, "R10 63 wins at higher priority");
        rd(S_FRC, 32'h0000_0003, 32'h0000_0003, "R11 force of 63 retired");

        // R12 next register writes
        access(S_NXT, O_WR, 32'hFFFF_FFFF, 1'b1, 32'h0000_0050, "R12 next write returns 20");
        rd(S_NXT, 32'h0, 32'h0000_0050, "R12 next unchanged");

        // R7 level clear, R9 empty again
        wr(S_LVL, O_CLR, 32'h0000_0003);
        rd(S_LVL, 32'h0, 32'h0000_0000, "R7 level cleared");
        wr(S_EN, O_CLR, 32'h0010_0001);
        rd(S_NXT, 32'h0, 32'h8000_0000, "R9 empty after disabling 20");
        pend_chk(1'b0, "R8 pending output low at end");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule